// File: doc/BRIEF.md
# Interrupt-Endpoint Poll Scheduler for a USB Host

This block lives inside a USB host controller and picks which interrupt endpoints receive a transaction during a frame. Each time the start-of-frame generator reports that a SOF token went out, the scheduler walks fifteen endpoint slots from the lowest number to the highest. It skips any slot that is disabled or whose single buffer is not ready for that slot's direction. For every slot that qualifies, it hands one request to a downstream transaction engine and waits for the result before it moves on.

Software programs the block through a small register port. Each slot has an active bit, a target descriptor (device address, endpoint number, direction, low-speed preamble flag) and a buffer control word. The block reports completed transfers in a write-one-to-clear done register, and an enable mask decides which of those done bits drive the interrupt line. If a SOF arrives while a scan is still running, it is remembered, and a fresh scan begins right after slot 15 has been handled.

Top module: `usb_intep_sched`

## Requirements
- R1: No scan starts and no request is issued until `sof_i` has been seen high on a clock edge; while idle without a SOF the block stays silent.
- R2: In a scan, slots are visited in ascending order 1..15. Only slots whose bit n of the active register (address 0x00) is set take part; bit 0 is unused.
- R3: In the buffer control word (address 0x20+n), bit 0 is FULL and bit 1 is AVAILABLE. A slot whose descriptor bit 11 is 0 (OUT) is ready when FULL=1 and AVAILABLE=1. A slot whose bit 11 is 1 (IN) is ready when AVAILABLE=1 and FULL=0.
- R4: A slot that is inactive or not ready produces no request, and the scan goes on to the next slot.
- R5: A request is a one-cycle `start_o` pulse. During the pulse, `req_dev_o`, `req_ep_o`, `req_dir_in_o` and `req_pre_o` carry descriptor bits [6:0], [10:7], [11] and [12] of the slot descriptor at address 0x10+n. No further request is issued until `done_i` returns.
- R6: Bits 16 and 17 of the buffer control word (the second buffer half) are ignored. They do not affect readiness and they read back as zero.
- R7: When `done_i` arrives with `result_i`=0 (ACK), done bit n of the status register (address 0x01) is set and AVAILABLE of slot n is cleared. For an IN slot, FULL is also set.
- R8: When `done_i` arrives with `result_i`=1 (NAK) or 2 (error), no status bit is set and the slot's buffer control is left unchanged.
- R9: Writing 1 to a status bit clears it. `irq_o` is high exactly when some status bit and the matching bit of the enable register (address 0x02) are both set. After reset, all registers read zero.
- R10: A SOF seen during a running scan is held as one pending scan, which starts at slot 1 right after slot 15. Further SOFs seen during the same scan add nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Pulse: a SOF token has been sent |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 6 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| start_o | output | 1 | One-cycle transaction request to the engine |
| req_dev_o | output | 7 | Device address of the request |
| req_ep_o | output | 4 | Endpoint number of the request |
| req_dir_in_o | output | 1 | Request direction, 1 = IN |
| req_pre_o | output | 1 | Low-speed preamble needed |
| done_i | input | 1 | Engine finished the current transaction |
| result_i | input | 2 | Outcome: 0 ACK, 1 NAK, 2 error |
| irq_o | output | 1 | Interrupt from enabled done bits |

## Verification
Random scans use random active masks, random directions and random FULL/AVAILABLE pairs with junk in the second buffer half. This separates the OUT and IN readiness rules and shows that skipped slots are never requested. Engine outcomes are drawn at random from ACK, NAK and error. Comparing the buffer and status readback with the model tells apart the one outcome that updates state from the two that must not. Directed runs cover the following: a long idle stretch without SOF; a slot that is ready only in its ignored half; scans forced to all-NAK and all-error; and scans that receive two extra SOFs. In the last case a NAKed slot must be polled exactly once more, never twice.

// File: rtl/usb_intep_pkg.sv
package usb_intep_pkg;
  localparam int unsigned DEV_W    = 7;
  localparam int unsigned EP_W     = 4;
  localparam int unsigned REG_AW   = 6;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CFG_BASE = 16;
  localparam int unsigned BUF_BASE = 32;

  localparam logic [REG_AW-1:0] A_ACTIVE = 6'h00;
  localparam logic [REG_AW-1:0] A_STATUS = 6'h01;
  localparam logic [REG_AW-1:0] A_IRQ_EN = 6'h02;

  typedef enum logic [1:0] {
    RES_ACK = 2'd0,
    RES_NAK = 2'd1,
    RES_ERR = 2'd2
  } xfer_res_e;

  typedef struct packed {
    logic            pre;
    logic            dir_in;
    logic [EP_W-1:0] ep;
    logic [DEV_W-1:0] dev;
  } slot_cfg_t;

  localparam int unsigned CFG_W = $bits(slot_cfg_t);
endpackage

// File: rtl/intep_slot_regs.sv
module intep_slot_regs
  import usb_intep_pkg::*;
#(
  parameter int unsigned NS = 15,
  localparam int unsigned SW = $clog2(NS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              cpl_valid_i,
  input  logic [SW-1:0]     cpl_slot_i,
  input  xfer_res_e         cpl_res_i,
  input  logic [SW-1:0]     sel_slot_i,
  output slot_cfg_t         sel_cfg_o,
  output logic [NS:0]       active_o,
  output logic [NS:0]       full_o,
  output logic [NS:0]       avail_o,
  output logic [NS:0]       dir_in_o,
  output logic              irq_o
);
  logic [NS:0] active_q, status_q, ien_q, full_q, avail_q;
  logic [NS:0] status_d, clr_mask, set_mask;
  slot_cfg_t   cfg_q [NS:0];
  logic        ack;

  assign ack = cpl_valid_i && (cpl_res_i == RES_ACK);

  always_comb begin
    clr_mask = '0;
    set_mask = '0;
    if (wr_en_i && wr_addr_i == A_STATUS) clr_mask = {wr_data_i[NS:1], 1'b0};
    if (ack) set_mask[cpl_slot_i] = 1'b1;
    status_d = (status_q & ~clr_mask) | set_mask;  // completion beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      status_q <= '0;
      ien_q    <= '0;
      full_q   <= '0;
      avail_q  <= '0;
      for (int s = 0; s <= NS; s++) cfg_q[s] <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == A_ACTIVE) active_q <= {wr_data_i[NS:1], 1'b0};
      if (wr_en_i && wr_addr_i == A_IRQ_EN) ien_q <= {wr_data_i[NS:1], 1'b0};
      status_q <= status_d;
      for (int s = 1; s <= NS; s++) begin
        if (wr_en_i && wr_addr_i == REG_AW'(CFG_BASE + s))
          cfg_q[s] <= slot_cfg_t'(wr_data_i[CFG_W-1:0]);
        if (wr_en_i && wr_addr_i == REG_AW'(BUF_BASE + s)) begin
          full_q[s]  <= wr_data_i[0];
          avail_q[s] <= wr_data_i[1];
        end
        if (ack && cpl_slot_i == SW'(s)) begin
          avail_q[s] <= 1'b0;
          if (cfg_q[s].dir_in) full_q[s] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_ACTIVE: rd_data_o = DATA_W'(active_q);
      A_STATUS: rd_data_o = DATA_W'(status_q);
      A_IRQ_EN: rd_data_o = DATA_W'(ien_q);
      default: begin
        for (int s = 1; s <= NS; s++) begin
          if (rd_addr_i == REG_AW'(CFG_BASE + s)) rd_data_o = DATA_W'(cfg_q[s]);
          if (rd_addr_i == REG_AW'(BUF_BASE + s)) rd_data_o = DATA_W'({avail_q[s], full_q[s]});
        end
      end
    endcase
  end

  generate
    for (genvar g = 0; g <= NS; g++) begin : g_dir
      assign dir_in_o[g] = cfg_q[g].dir_in;
    end
  endgenerate

  assign sel_cfg_o = cfg_q[sel_slot_i];
  assign active_o  = active_q;
  assign full_o    = full_q;
  assign avail_o   = avail_q;
  assign irq_o     = |(status_q & ien_q);

  a_r7_status_set_only_by_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q)) == '0) ||
             ($past(cpl_valid_i) && $past(cpl_res_i) == RES_ACK));

  a_r8_nak_err_keep_buffer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_i && cpl_res_i != RES_ACK && !wr_en_i) |=> $stable(avail_q) && $stable(full_q));
endmodule

// File: rtl/intep_ready_check.sv
module intep_ready_check #(
  parameter int unsigned NS = 15
) (
  input  logic [NS:0] active_i,
  input  logic [NS:0] full_i,
  input  logic [NS:0] avail_i,
  input  logic [NS:0] dir_in_i,
  output logic [NS:0] ready_o
);
  generate
    for (genvar g = 0; g <= NS; g++) begin : g_slot
      // OUT wants a filled buffer, IN wants an empty one
      assign ready_o[g] = active_i[g] & avail_i[g] & (dir_in_i[g] ? ~full_i[g] : full_i[g]);
    end
  endgenerate
endmodule

// File: rtl/intep_scan_seq.sv
module intep_scan_seq #(
  parameter int unsigned NS = 15,
  localparam int unsigned SW = $clog2(NS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sof_i,
  input  logic [NS:0]   ready_i,
  input  logic          done_i,
  output logic          start_o,
  output logic [SW-1:0] slot_o,
  output logic          cpl_valid_o
);
  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_WAIT} seq_st_e;

  seq_st_e       st_q, st_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          pend_q, pend_d, start_q, start_d, adv;

  always_comb begin
    st_d    = st_q;
    slot_d  = slot_q;
    pend_d  = pend_q;
    start_d = 1'b0;
    adv     = 1'b0;
    unique case (st_q)
      S_IDLE: if (sof_i) begin
        st_d   = S_CHECK;
        slot_d = SW'(1);
      end
      S_CHECK: if (ready_i[slot_q]) begin
        st_d    = S_WAIT;
        start_d = 1'b1;
      end else adv = 1'b1;
      S_WAIT: if (done_i) adv = 1'b1;
      default: st_d = S_IDLE;
    endcase
    if (st_q != S_IDLE && sof_i) pend_d = 1'b1;
    if (adv) begin
      st_d = S_CHECK;
      if (slot_q == SW'(NS)) begin
        if (pend_d) begin
          slot_d = SW'(1);
          pend_d = 1'b0;
        end else st_d = S_IDLE;
      end else slot_d = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      slot_q  <= '0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      slot_q  <= slot_d;
      pend_q  <= pend_d;
      start_q <= start_d;
    end
  end

  assign start_o     = start_q;
  assign slot_o      = slot_q;
  assign cpl_valid_o = (st_q == S_WAIT) && done_i;

  a_r1_idle_without_sof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && !sof_i) |=> (st_q == S_IDLE) && !start_q);

  a_r2_ascending_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(slot_q) || (slot_q == $past(slot_q) + 1'b1) || (slot_q == SW'(1)));

  a_r5_single_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);

  a_r5_hold_slot_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WAIT && !done_i) |=> $stable(slot_q) && !start_q);
endmodule

// File: rtl/usb_intep_sched.sv
module usb_intep_sched
  import usb_intep_pkg::*;
#(
  parameter int unsigned NS = 15,
  localparam int unsigned SW = $clog2(NS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              start_o,
  output logic [DEV_W-1:0]  req_dev_o,
  output logic [EP_W-1:0]   req_ep_o,
  output logic              req_dir_in_o,
  output logic              req_pre_o,
  input  logic              done_i,
  input  logic [1:0]        result_i,
  output logic              irq_o
);
  logic [NS:0]   active_w, full_w, avail_w, dir_w, ready_w;
  logic [SW-1:0] slot_w;
  logic          cpl_w;
  slot_cfg_t     cur_cfg;

  intep_slot_regs #(.NS(NS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .cpl_valid_i(cpl_w),
    .cpl_slot_i (slot_w),
    .cpl_res_i  (xfer_res_e'(result_i)),
    .sel_slot_i (slot_w),
    .sel_cfg_o  (cur_cfg),
    .active_o   (active_w),
    .full_o     (full_w),
    .avail_o    (avail_w),
    .dir_in_o   (dir_w),
    .irq_o      (irq_o)
  );

  intep_ready_check #(.NS(NS)) u_ready (
    .active_i(active_w),
    .full_i  (full_w),
    .avail_i (avail_w),
    .dir_in_i(dir_w),
    .ready_o (ready_w)
  );

  intep_scan_seq #(.NS(NS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sof_i      (sof_i),
    .ready_i    (ready_w),
    .done_i     (done_i),
    .start_o    (start_o),
    .slot_o     (slot_w),
    .cpl_valid_o(cpl_w)
  );

  assign req_dev_o    = cur_cfg.dev;
  assign req_ep_o     = cur_cfg.ep;
  assign req_dir_in_o = cur_cfg.dir_in;
  assign req_pre_o    = cur_cfg.pre;

  a_r3_start_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(ready_w[slot_w]));
endmodule

// File: tb/usb_intep_sched_tb_top.sv
module usb_intep_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof_i = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        start;
  logic [6:0]  req_dev;
  logic [3:0]  req_ep;
  logic        req_dir, req_pre;
  logic        done_i = 1'b0;
  logic [1:0]  result_i = '0;
  logic        irq;

  int total = 0;
  int bad = 0;
  int force_res = -1;

  logic [12:0] m_cfg [16];
  bit          m_act [16];
  bit          m_full [16];
  bit          m_av [16];
  logic [15:0] m_stat = '0;
  logic [15:0] m_en = '0;

  always #4 clk = ~clk;

  usb_intep_sched dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof_i),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .start_o(start), .req_dev_o(req_dev), .req_ep_o(req_ep),
    .req_dir_in_o(req_dir), .req_pre_o(req_pre),
    .done_i(done_i), .result_i(result_i), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  function automatic bit m_ready(input int s);
    return m_act[s] && m_av[s] && (m_cfg[s][11] ? !m_full[s] : m_full[s]);
  endfunction

  function automatic int next_slot(input int from);
    for (int s = from; s <= 15; s++) if (m_ready(s)) return s;
    return 0;
  endfunction

  task automatic set_slot(input int s, input bit act, input bit dir_in, input logic [1:0] buf_lo,
                          input logic [1:0] buf_hi);
    logic [12:0] c;
    c = {1'($urandom), dir_in, 4'($urandom), 7'(s)};
    m_cfg[s] = c;
    m_full[s] = buf_lo[0];
    m_av[s] = buf_lo[1];
    m_act[s] = act;
    wr(6'(16 + s), {19'd0, c});
    wr(6'(32 + s), {14'd0, buf_hi, 14'd0, buf_lo});
  endtask

  task automatic write_active();
    logic [15:0] a;
    a = '0;
    for (int s = 1; s <= 15; s++) a[s] = m_act[s];
    wr(6'h00, {16'd0, a});
  endtask

  // Engine model plus scan check: one call covers one SOF and anything it triggers
  task automatic run_round(input bit extra);
    int last, pend, idle, cyc, exp, s, lat, r;
    logic [1:0] res;
    last = 0; pend = 0; idle = 0; cyc = 0;
    @(negedge clk);
    sof_i = 1'b1;
    while (idle < 40) begin
      @(negedge clk);
      cyc++;
      sof_i = extra && (cyc == 3 || cyc == 5);
      if (sof_i) pend = 1;
      if (start) begin
        idle = 0;
        exp = next_slot(last + 1);
        if (exp == 0 && pend != 0) begin
          pend = 0;
          exp = next_slot(1);
        end
        total++;
        if (exp == 0) begin
          bad++;
          $display("FAIL R4 R3 unexpected request actual=%0d expected=none", req_dev);
          s = int'(req_dev) % 16;
        end else begin
          s = exp;
          chk("R2 R10 slot order", 32'(req_dev), 32'(m_cfg[s][6:0]));
          chk("R5 endpoint field", 32'(req_ep), 32'(m_cfg[s][10:7]));
          chk("R5 direction field", 32'(req_dir), 32'(m_cfg[s][11]));
          chk("R5 preamble field", 32'(req_pre), 32'(m_cfg[s][12]));
        end
        last = s;
        r = int'($urandom % 4);
        res = (force_res >= 0) ? 2'(force_res) : (r < 2 ? 2'd0 : 2'(r - 1));
        lat = 1 + int'($urandom % 4);
        repeat (lat) begin
          @(negedge clk);
          sof_i = 1'b0;
          if (start) chk("R5 no second start before done", 32'(start), 32'd0);
        end
        done_i = 1'b1; result_i = res;
        @(negedge clk);
        done_i = 1'b0;
        if (res == 2'd0 && s != 0) begin
          m_av[s] = 0;
          if (m_cfg[s][11]) m_full[s] = 1;
          m_stat[s] = 1'b1;
        end
      end else idle++;
    end
    sof_i = 1'b0;
    exp = next_slot(last + 1);
    if (exp == 0 && pend != 0) exp = next_slot(1);
    chk("R4 R2 R10 no ready slot left unpolled", 32'(exp), 32'd0);
  endtask

  task automatic check_state(input string tag);
    logic [31:0] d;
    for (int s = 1; s <= 15; s++) begin
      rd(6'(32 + s), d);
      chk({tag, " R6 R7 R8 buffer readback"}, d, {30'd0, m_av[s], m_full[s]});
    end
    rd(6'h01, d);
    chk({tag, " R7 R8 status"}, d, {16'd0, m_stat});
    chk({tag, " R9 irq"}, 32'(irq), 32'(|(m_stat & m_en)));
  endtask

  task automatic random_config();
    logic [15:0] clr;
    for (int s = 1; s <= 15; s++)
      set_slot(s, 1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom));
    write_active();
    m_en = 16'($urandom) & 16'hfffe;
    wr(6'h02, {16'd0, m_en});
    clr = 16'($urandom);
    wr(6'h01, {16'd0, clr});
    m_stat = m_stat & ~{clr[15:1], 1'b0};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int seen;
    void'($urandom(32'd2417));
    for (int s = 0; s < 16; s++) begin
      m_cfg[s] = '0; m_act[s] = 0; m_full[s] = 0; m_av[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    rd(6'h00, d); chk("R9 reset active", d, 32'd0);
    rd(6'h01, d); chk("R9 reset status", d, 32'd0);
    rd(6'h02, d); chk("R9 reset enable", d, 32'd0);
    rd(6'h21, d); chk("R9 reset buffer", d, 32'd0);
    chk("R9 reset irq", 32'(irq), 32'd0);
    chk("R1 reset start", 32'(start), 32'd0);

    // R1: ready slot but no SOF
    set_slot(1, 1, 0, 2'b11, 2'b00);
    write_active();
    seen = 0;
    repeat (60) begin
      @(negedge clk);
      if (start) seen++;
    end
    chk("R1 no request without SOF", 32'(seen), 32'd0);
    run_round(0);
    check_state("R1 first round");

    // R6: only the ignored half looks ready
    for (int s = 1; s <= 15; s++) set_slot(s, 0, 0, 2'b00, 2'b00);
    set_slot(2, 1, 0, 2'b00, 2'b11);
    set_slot(3, 1, 1, 2'b00, 2'b10);
    set_slot(4, 1, 1, 2'b10, 2'b01);
    write_active();
    rd(6'h22, d); chk("R6 upper half reads zero", d, 32'd0);
    run_round(0);
    check_state("R6 R3");

    // R3: every direction/buffer combination on active slots
    for (int s = 1; s <= 15; s++) set_slot(s, 1, 1'(s % 2), 2'(s / 2), 2'($urandom));
    write_active();
    force_res = 0;
    run_round(0);
    check_state("R3 R7 all ack");

    // R8: forced NAK, then forced error
    for (int s = 1; s <= 15; s++) set_slot(s, 1, 1'(s % 2), 2'b10 | 2'(~s % 2), 2'b00);
    write_active();
    force_res = 1;
    run_round(0);
    check_state("R8 nak");
    force_res = 2;
    run_round(0);
    check_state("R8 error");

    // R10: NAKed slots polled once more after extra SOFs, never twice
    force_res = 1;
    run_round(1);
    check_state("R10 pending round");
    force_res = -1;

    // R9: interrupt enable and write-one-to-clear
    m_en = 16'hfffe;
    wr(6'h02, 32'h0000fffe);
    @(negedge clk);
    chk("R9 irq enabled", 32'(irq), 32'(|m_stat));
    wr(6'h01, 32'h0000ffff);
    m_stat = '0;
    rd(6'h01, d); chk("R9 w1c clears status", d, 32'd0);
    chk("R9 irq low after clear", 32'(irq), 32'd0);

    // random scans
    for (int i = 0; i < 30; i++) begin
      random_config();
      run_round((i % 3) == 2);
      check_state("random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule